// File: doc/BRIEF.md
# PPS-Latched Timekeeper

This block keeps absolute time as a pair of 32-bit counts: whole seconds, and clock ticks inside the current second. The tick count advances on every clock and rolls over into the seconds count once per second, where the length of a second is a parameter (100,000,000 ticks for a 100 MHz clock by default).

Software sets the time through four write-only word registers. A seconds value and a ticks value are staged in holding registers. The block then commits them either at once or on the next pulse-per-second edge. Before the edge is seen, the pulse can come from one of two asynchronous inputs, and either its rising or its falling edge can be chosen. Every selected edge also produces a one-cycle event pulse for an interrupt controller. A small read port returns the seconds count and then a ticks value taken in the same cycle, so that software can read a 64-bit time that belongs together.

The control path is a two-state machine. `ST_IDLE` means no load is waiting. `ST_ARMED` means a staged time waits for a PPS edge. The transitions are:
- **T_ARM**: `ST_IDLE` to `ST_ARMED` on a deferred commit write.
- **T_REARM**: `ST_ARMED` stays `ST_ARMED` on a deferred commit write.
- **T_FIRE**: `ST_ARMED` to `ST_IDLE` on a selected edge, and the staged time loads.
- **T_FORCE**: either state to `ST_IDLE` on an immediate commit write, and the staged time loads.

Top module: `pps_timekeeper`

## Requirements
- R1: After reset, `now_secs`, `now_ticks`, `rd_data` and `pps_event` are 0. The edge select is falling, the source is `pps_ext`, and no load is pending.
- R2: With no load, `now_ticks` rises by one per clock. In the cycle after `now_ticks` is at or above TICKS_PER_SEC-1, `now_ticks` is 0 and `now_secs` has risen by one.
- R3: A write of 1 in bit 0 to word 3 (commit) loads the staged seconds (word 0) and ticks (word 1) on that same clock edge, in either state. The next cycle shows exactly the staged values.
- R4: A write of 0 in bit 0 to word 3 arms the block. The staged time loads on the clock edge where the selected PPS edge is detected. That is the third rising clock edge after the input level changes, because of two synchroniser flops and one edge flop.
- R5: Word 2 bit 0 picks the edge: 0 means falling, 1 means rising. The other edge of the selected input loads nothing and raises no event.
- R6: Word 2 bit 1 picks the source: 0 means `pps_ext`, 1 means `pps_link`. Edges on the unselected input load nothing and raise no event.
- R7: An armed load fires once. Later selected edges do not reload the time unless word 3 is written again.
- R8: Each selected edge raises `pps_event` for exactly one cycle, in the same cycle that an armed load becomes visible, whether or not a load is armed.
- R9: A read with `rd_addr`=0 returns `now_secs` on `rd_data` one cycle later and captures `now_ticks` in that same cycle. A read with `rd_addr`=1 returns that captured ticks value.
- R10: Writes to words 0, 1 and 2 do not change `now_secs` or `now_ticks`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Word index: 0 seconds, 1 ticks, 2 flags, 3 commit |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 seconds (captures ticks), 1 captured ticks |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| pps_ext | input | 1 | First asynchronous PPS input |
| pps_link | input | 1 | Second asynchronous PPS input |
| pps_event | output | 1 | One-cycle pulse per selected PPS edge |
| now_secs | output | 32 | Live seconds count |
| now_ticks | output | 32 | Live ticks count |

## Verification
The assertions assume that each PPS level lasts at least two clocks. This lets the event pulse be checked as never lasting two cycles. The bench holds every random PPS level for at least three cycles. The checks also assume that a staged ticks value written by software stays below one second. Random ticks writes are therefore drawn below TICKS_PER_SEC, and the wrap check still covers values at or above the limit. Writes go through the single write port one at a time, so a commit never lands in the same cycle as a write to a staged value.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int DATA_W = 32;

    localparam logic [1:0] REG_SECS  = 2'd0;
    localparam logic [1:0] REG_TICKS = 2'd1;
    localparam logic [1:0] REG_FLAGS = 2'd2;
    localparam logic [1:0] REG_IMM   = 2'd3;

    localparam logic RD_SECS  = 1'b0;
    localparam logic RD_TICKS = 1'b1;

    typedef struct packed {
        logic src_link;   // bit 1: 1 selects the second PPS input
        logic edge_rise;  // bit 0: 1 selects the rising edge
    } tk_flags_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } tk_state_e;

endpackage

// File: rtl/tk_pps_edge.sv
module tk_pps_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_async,
    output logic rise,
    output logic fall
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= pps_async;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[MSB-1:0], pps_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[MSB];
    end

    assign rise = chain[MSB] & ~prev;
    assign fall = ~chain[MSB] & prev;
endmodule

// File: rtl/tk_regs.sv
module tk_regs
    import tk_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] stage_secs,
    output logic [W-1:0] stage_ticks,
    output tk_flags_t    flags,
    output logic         commit_wr,
    output logic         commit_now
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_secs  <= '0;
            stage_ticks <= '0;
            flags       <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_SECS:  stage_secs  <= wr_data;
                REG_TICKS: stage_ticks <= wr_data;
                REG_FLAGS: flags       <= tk_flags_t'(wr_data[1:0]);
                REG_IMM:   ;
            endcase
        end
    end

    assign commit_wr  = wr_en && (wr_addr == REG_IMM);
    assign commit_now = wr_data[0];
endmodule

// File: rtl/tk_ctrl.sv
module tk_ctrl
    import tk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      commit_wr,
    input  logic      commit_now,
    input  logic      pps_edge,
    output logic      load,
    output tk_state_e state
);
    tk_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (commit_wr) begin
                    if (commit_now) load = 1'b1;     // T_FORCE
                    else            nxt  = ST_ARMED; // T_ARM
                end
            end
            ST_ARMED: begin
                if (commit_wr) begin
                    if (commit_now) begin            // T_FORCE
                        load = 1'b1;
                        nxt  = ST_IDLE;
                    end                              // else T_REARM
                end else if (pps_edge) begin         // T_FIRE
                    load = 1'b1;
                    nxt  = ST_IDLE;
                end
            end
        endcase
    end
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
    parameter int W             = 32,
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_secs,
    input  logic [W-1:0] load_ticks,
    output logic [W-1:0] secs,
    output logic [W-1:0] ticks
);
    localparam logic [W-1:0] LAST_TICK = W'(TICKS_PER_SEC - 1);

    logic at_end;
    assign at_end = (ticks >= LAST_TICK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs  <= '0;
            ticks <= '0;
        end else if (load) begin
            secs  <= load_secs;
            ticks <= load_ticks;
        end else if (at_end) begin
            secs  <= secs + 1'b1;
            ticks <= '0;
        end else begin
            ticks <= ticks + 1'b1;
        end
    end
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
    import tk_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pps_ext,
    input  logic              pps_link,
    output logic              pps_event,
    output logic [DATA_W-1:0] now_secs,
    output logic [DATA_W-1:0] now_ticks
);
    localparam int N_SRC = 2;

    logic [DATA_W-1:0] stage_secs;
    logic [DATA_W-1:0] stage_ticks;
    tk_flags_t         flags;
    logic              commit_wr;
    logic              commit_now;
    logic              load;
    tk_state_e         state;
    logic [DATA_W-1:0] tick_shadow;

    logic [N_SRC-1:0] pps_in;
    logic [N_SRC-1:0] rise_v;
    logic [N_SRC-1:0] fall_v;
    logic             sel_edge;

    assign pps_in = {pps_link, pps_ext};

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            tk_pps_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk       (clk),
                .rst_n     (rst_n),
                .pps_async (pps_in[i]),
                .rise      (rise_v[i]),
                .fall      (fall_v[i])
            );
        end
    endgenerate

    always_comb begin
        logic idx;
        idx      = flags.src_link;
        sel_edge = flags.edge_rise ? rise_v[idx] : fall_v[idx];
    end

    tk_regs #(.W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .stage_secs  (stage_secs),
        .stage_ticks (stage_ticks),
        .flags       (flags),
        .commit_wr   (commit_wr),
        .commit_now  (commit_now)
    );

    tk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_wr  (commit_wr),
        .commit_now (commit_now),
        .pps_edge   (sel_edge),
        .load       (load),
        .state      (state)
    );

    tk_counter #(.W(DATA_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_secs  (stage_secs),
        .load_ticks (stage_ticks),
        .secs       (now_secs),
        .ticks      (now_ticks)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pps_event <= 1'b0;
        else        pps_event <= sel_edge;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data     <= '0;
            tick_shadow <= '0;
        end else if (rd_en) begin
            if (rd_addr == RD_SECS) begin
                rd_data     <= now_secs;
                tick_shadow <= now_ticks;
            end else begin
                rd_data     <= tick_shadow;
            end
        end
    end
endmodule

// File: rtl/tk_checker.sv
module tk_checker
    import tk_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_wr,
    input logic              commit_now,
    input logic              rd_en,
    input logic              rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              pps_event,
    input logic [DATA_W-1:0] now_secs,
    input logic [DATA_W-1:0] now_ticks,
    input logic [DATA_W-1:0] stage_secs,
    input logic [DATA_W-1:0] stage_ticks,
    input logic              load,
    input tk_state_e         state
);
    localparam logic [DATA_W-1:0] LAST = DATA_W'(TICKS_PER_SEC - 1);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !load && now_ticks < LAST) |=> (now_ticks == $past(now_ticks) + 1'b1)); // R2
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !load && now_ticks >= LAST) |=> (now_ticks == '0 && now_secs == $past(now_secs) + 1'b1)); // R2
    AST_IMM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_wr && commit_now) |-> load); // R3
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && load) |=> (now_secs == $past(stage_secs) && now_ticks == $past(stage_ticks))); // R4
    AST_NO_SPONT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !commit_wr) |-> !load); // R7
    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pps_event |=> !pps_event); // R8
    AST_RD_SECS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rd_en && rd_addr == RD_SECS) |=> (rd_data == $past(now_secs))); // R9
endmodule

bind pps_timekeeper tk_checker #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_wr   (commit_wr),
    .commit_now  (commit_now),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .pps_event   (pps_event),
    .now_secs    (now_secs),
    .now_ticks   (now_ticks),
    .stage_secs  (stage_secs),
    .stage_ticks (stage_ticks),
    .load        (load),
    .state       (state)
);

// File: tb/pps_timekeeper_test.sv
module pps_timekeeper_test;
    localparam int TPS = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        pps_ext = 1'b0;
    logic        pps_link = 1'b0;
    logic        pps_event;
    logic [31:0] now_secs;
    logic [31:0] now_ticks;

    always #5 clk = ~clk;

    pps_timekeeper #(.TICKS_PER_SEC(TPS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pps_ext(pps_ext), .pps_link(pps_link), .pps_event(pps_event),
        .now_secs(now_secs), .now_ticks(now_ticks)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_tag = "R2";

    // bench model state
    logic [31:0] es = 0, et = 0, ps = 0, pt = 0, erd = 0, eshadow = 0;
    logic [1:0]  mflags = 0;
    bit          marmed = 0, eevt = 0, rd_chk = 0, loaded = 0, imm_load = 0;
    logic [3:0]  ha = 0, hb = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit edge_of(input logic [3:0] h, input bit rise);
        return rise ? (h[2] & ~h[3]) : (~h[2] & h[3]);
    endfunction

    task automatic model_step();
        logic [31:0] os, ot;
        bit evt, imm;
        os = es; ot = et;
        ha = {ha[2:0], pps_ext};
        hb = {hb[2:0], pps_link};
        evt = mflags[1] ? edge_of(hb, mflags[0]) : edge_of(ha, mflags[0]);
        imm = wr_en && wr_addr == 2'd3;
        loaded = 0; imm_load = 0;
        if (imm) begin
            if (wr_data[0]) begin loaded = 1; imm_load = 1; marmed = 0; end
            else marmed = 1;
        end else if (marmed && evt) begin
            loaded = 1; marmed = 0;
        end
        if (loaded) begin es = ps; et = pt; end
        else if (et >= TPS - 1) begin et = 0; es = es + 1; end
        else et = et + 1;
        if (wr_en) begin
            case (wr_addr)
                2'd0: ps = wr_data;
                2'd1: pt = wr_data;
                2'd2: mflags = wr_data[1:0];
                default: ;
            endcase
        end
        rd_chk = rd_en;
        if (rd_en) begin
            if (!rd_addr) begin erd = os; eshadow = ot; end
            else erd = eshadow;
        end
        eevt = evt;
    endtask

    task automatic cyc();
        string t;
        @(posedge clk);
        model_step();
        @(negedge clk);
        t = loaded ? (imm_load ? "R3" : "R4") : cur_tag;
        chk({t, " secs"}, now_secs, es);
        chk({t, " ticks"}, now_ticks, et);
        chk(eevt ? "R8 event" : {cur_tag, " event"}, {31'd0, pps_event}, {31'd0, eevt});
        if (rd_chk) chk("R9 read", rd_data, erd);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; wr_addr = a; wr_data = d; cyc();
    endtask

    task automatic rd(input logic a);
        rd_en = 1; rd_addr = a; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int hold_a, hold_b, r;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 secs", now_secs, 0);
        chk("R1 ticks", now_ticks, 0);
        chk("R1 event", {31'd0, pps_event}, 0);
        chk("R1 rd_data", rd_data, 0);

        cur_tag = "R2"; idle(2 * TPS + 5);
        chk("R2 wrap count", now_secs, 2);

        cur_tag = "R10"; wr(0, 100); wr(1, 5); wr(2, 0); idle(3);
        cur_tag = "R3";  wr(3, 1); idle(2);
        cur_tag = "R9";  rd(0); idle(3); rd(1); rd(0); rd(1);

        // R4: deferred load on falling edge of pps_ext; rising edge ignored (R5)
        cur_tag = "R4"; wr(0, 200); wr(1, 10); wr(3, 0); idle(5);
        cur_tag = "R5"; pps_ext = 1; idle(6);
        chk("R5 rising ignored", now_secs, es);
        cur_tag = "R4"; pps_ext = 0; idle(6);
        chk("R4 loaded secs", now_secs, 200);
        // R7: no reload without a new arm
        cur_tag = "R7"; pps_ext = 1; idle(6); pps_ext = 0; idle(6);
        chk("R7 no reload", now_secs, 200);

        // R5: rising edge selected
        cur_tag = "R5"; wr(2, 1); wr(0, 300); wr(1, 0); wr(3, 0); idle(2);
        pps_ext = 1; idle(6);
        chk("R5 rising load", now_secs, 300);
        pps_ext = 0; idle(4);

        // R6: second source, rising edge; first source ignored
        cur_tag = "R6"; wr(2, 3); wr(0, 400); wr(3, 0);
        pps_ext = 1; idle(6); pps_ext = 0; idle(6);
        chk("R6 other source ignored", now_secs, 300);
        pps_link = 1; idle(6);
        chk("R6 link load", now_secs, 400);
        pps_link = 0; idle(4);

        // R3: immediate commit overrides an armed load
        cur_tag = "R3"; wr(0, 500); wr(1, TPS + 3); wr(3, 0); wr(3, 1); idle(3);
        wr(2, 0); idle(2);

        // constrained random phase
        cur_tag = "R2"; hold_a = 5; hold_b = 9;
        for (int n = 0; n < 4000; n++) begin
            r = $urandom % 100;
            if (r < 4)       begin wr_en = 1; wr_addr = 0; wr_data = $urandom; end
            else if (r < 8)  begin wr_en = 1; wr_addr = 1; wr_data = $urandom % TPS; end
            else if (r < 11) begin wr_en = 1; wr_addr = 2; wr_data = $urandom % 4; end
            else if (r < 15) begin wr_en = 1; wr_addr = 3; wr_data = $urandom % 2; end
            if (r >= 10 && r < 30) begin rd_en = 1; rd_addr = 1'($urandom % 2); end
            hold_a--; hold_b--;
            if (hold_a <= 0) begin pps_ext  = ~pps_ext;  hold_a = 3 + $urandom % 30; end
            if (hold_b <= 0) begin pps_link = ~pps_link; hold_b = 3 + $urandom % 30; end
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule